// File: doc/BRIEF.md
# GPIO Interrupt Aggregator

This block turns a bank of general-purpose input lines into a small number of interrupt requests. Every pin is first brought into the clock domain through a two-stage synchroniser, then optionally inverted by a per-line polarity bit to give the line's data-in value. Active-high or active-low sensing is therefore chosen by a single register, and so is rising-edge or falling-edge sensing.

Two cause sources exist per line. The level cause is simply the data-in bit gated by a level-mask bit. The edge cause is a sticky bit that is set whenever data-in goes from 0 to 1. It stays set until software writes a 0 to it, and it is gated by an edge-mask bit. The lines are split into groups of eight. Each group ORs its masked causes into one interrupt output for a downstream interrupt controller. Lines that the chip's I/O configuration marks as outputs never produce a cause. Software reaches the registers through a plain address/write-enable bus with read data returned one cycle later. Sensing on both edges is left to software, which flips the polarity bit after each event.

Top module: `gpio_irq_agg`

## Requirements
- R1: The data-in value of a line equals its synchronised pin XOR its polarity bit. Polarity is read and written at offset 0x00. Data-in is read at offset 0x04, and writes to 0x04 are ignored.
- R2: A line's level cause is its data-in bit AND its level-mask bit (offset 0x10), and it is present for as long as both are 1.
- R3: A 0-to-1 change of a line's data-in sets that line's bit in the edge-cause register (offset 0x08). The bit stays set after data-in returns to 0. With polarity 1, this makes a falling pin edge the trigger.
- R4: A write to offset 0x08 clears every edge-cause bit written as 0 and leaves every bit written as 1 unchanged.
- R5: When a new edge and a write-zero clear hit the same edge-cause bit in the same cycle, the bit ends up set.
- R6: A line's edge cause reaches the outputs only while its bit in the edge-mask register (offset 0x0C) is 1. Clearing the mask does not clear the latched cause.
- R7: Output bit g of `grp_irq` is the OR of the masked level and masked edge causes of lines 8g to 8g+7.
- R8: After reset, polarity, edge cause, edge mask and level mask all read 0, and `grp_irq` is 0.
- R9: A line whose `line_is_input` bit is 0 sets neither a level cause nor an edge-cause bit.
- R10: Read data appears on `bus_rdata` in the cycle after the address is presented. Offsets other than 0x00 to 0x10 read as 0, and writes to them change no register.
- R11: A pin change reaches data-in and the level cause after exactly two rising clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NUM_LINES | Raw, asynchronous GPIO pin values |
| line_is_input | input | NUM_LINES | 1 marks a line configured as input |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr_en | input | 1 | Write strobe for bus_addr |
| bus_wdata | input | NUM_LINES | Write data |
| bus_rdata | output | NUM_LINES | Registered read data for the previous cycle's address |
| grp_irq | output | NUM_LINES/GROUP_SIZE | Per-group interrupt requests |

## Verification
The bench walks a single active line across every position, in both level and edge modes and under both polarities. A design that maps lines to the wrong group, or that inverts in the wrong place, raises the wrong output or none at all. It writes words with mixed zeros and ones to the edge-cause register, and it lines up a fresh edge with a clearing write in the same cycle. A design with write-one-to-clear semantics, or one where the clear takes priority, loses a pending interrupt. It also counts the exact synchroniser delay, masks out lines configured as outputs, and probes unmapped and read-only offsets. This catches designs whose causes leak from output lines or whose stray writes corrupt the masks.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // Register byte offsets
  localparam int OFS_POLARITY   = 'h00;
  localparam int OFS_DATA_IN    = 'h04;
  localparam int OFS_EDGE_CAUSE = 'h08;
  localparam int OFS_EDGE_MASK  = 'h0C;
  localparam int OFS_LEVEL_MASK = 'h10;

  localparam int MAX_LINES = 64;

  // Polarity-corrected input value
  function automatic logic [MAX_LINES-1:0] din_calc(
    input logic [MAX_LINES-1:0] pins,
    input logic [MAX_LINES-1:0] pol
  );
    return pins ^ pol;
  endfunction

  // Next edge-cause value: zeros in a clearing write drop bits, new edges win
  function automatic logic [MAX_LINES-1:0] edge_next(
    input logic [MAX_LINES-1:0] cur,
    input logic                 clr,
    input logic [MAX_LINES-1:0] keep,
    input logic [MAX_LINES-1:0] hit
  );
    logic [MAX_LINES-1:0] kept;
    kept = clr ? (cur & keep) : cur;
    return kept | hit;
  endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int ADDR_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr_en,
  input  logic [NUM_LINES-1:0] bus_wdata,
  input  logic [NUM_LINES-1:0] sync_pin,
  input  logic [NUM_LINES-1:0] line_is_input,
  output logic [NUM_LINES-1:0] bus_rdata,
  output logic [NUM_LINES-1:0] data_in,
  output logic [NUM_LINES-1:0] edge_cause,
  output logic [NUM_LINES-1:0] edge_mask,
  output logic [NUM_LINES-1:0] level_mask,
  output logic [NUM_LINES-1:0] edge_hit,
  output logic                 clr_we,
  output logic                 addr_hit
);

  localparam logic [ADDR_W-1:0] A_POL = ADDR_W'(OFS_POLARITY);
  localparam logic [ADDR_W-1:0] A_DIN = ADDR_W'(OFS_DATA_IN);
  localparam logic [ADDR_W-1:0] A_EC  = ADDR_W'(OFS_EDGE_CAUSE);
  localparam logic [ADDR_W-1:0] A_EM  = ADDR_W'(OFS_EDGE_MASK);
  localparam logic [ADDR_W-1:0] A_LM  = ADDR_W'(OFS_LEVEL_MASK);

  logic [NUM_LINES-1:0] polarity;
  logic [NUM_LINES-1:0] prev_din;
  logic [MAX_LINES-1:0] din_wide;
  logic [MAX_LINES-1:0] ec_wide;

  always_comb begin
    din_wide = din_calc(MAX_LINES'(sync_pin), MAX_LINES'(polarity));
    data_in  = din_wide[NUM_LINES-1:0];
  end

  assign edge_hit = data_in & ~prev_din & line_is_input;
  assign clr_we   = bus_wr_en && (bus_addr == A_EC);
  assign addr_hit = (bus_addr == A_POL) || (bus_addr == A_DIN) ||
                    (bus_addr == A_EC)  || (bus_addr == A_EM)  ||
                    (bus_addr == A_LM);

  always_comb begin
    ec_wide = edge_next(MAX_LINES'(edge_cause), clr_we,
                        MAX_LINES'(bus_wdata), MAX_LINES'(edge_hit));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      polarity   <= '0;
      edge_mask  <= '0;
      level_mask <= '0;
      edge_cause <= '0;
      prev_din   <= '0;
    end else begin
      prev_din   <= data_in;
      edge_cause <= ec_wide[NUM_LINES-1:0];
      if (bus_wr_en && bus_addr == A_POL) polarity   <= bus_wdata;
      if (bus_wr_en && bus_addr == A_EM)  edge_mask  <= bus_wdata;
      if (bus_wr_en && bus_addr == A_LM)  level_mask <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else begin
      unique case (1'b1)
        (bus_addr == A_POL): bus_rdata <= polarity;
        (bus_addr == A_DIN): bus_rdata <= data_in;
        (bus_addr == A_EC):  bus_rdata <= edge_cause;
        (bus_addr == A_EM):  bus_rdata <= edge_mask;
        (bus_addr == A_LM):  bus_rdata <= level_mask;
        default:             bus_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/gpio_irq_group.sv
module gpio_irq_group #(
  parameter int NUM_LINES  = 32,
  parameter int GROUP_SIZE = 8,
  localparam int NUM_GROUPS = NUM_LINES / GROUP_SIZE
) (
  input  logic [NUM_LINES-1:0]  cause,
  output logic [NUM_GROUPS-1:0] grp_irq
);

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    assign grp_irq[g] = |cause[g*GROUP_SIZE +: GROUP_SIZE];
  end

endmodule

// File: rtl/gpio_irq_agg.sv
module gpio_irq_agg #(
  parameter int NUM_LINES  = 32,
  parameter int GROUP_SIZE = 8,
  parameter int ADDR_W     = 8,
  parameter int SYNC_DEPTH = 2,
  localparam int NUM_GROUPS = NUM_LINES / GROUP_SIZE
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_LINES-1:0]  pin_in,
  input  logic [NUM_LINES-1:0]  line_is_input,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_wr_en,
  input  logic [NUM_LINES-1:0]  bus_wdata,
  output logic [NUM_LINES-1:0]  bus_rdata,
  output logic [NUM_GROUPS-1:0] grp_irq
);

  logic [NUM_LINES-1:0] sync_pin;
  logic [NUM_LINES-1:0] data_in;
  logic [NUM_LINES-1:0] edge_cause;
  logic [NUM_LINES-1:0] edge_mask;
  logic [NUM_LINES-1:0] level_mask;
  logic [NUM_LINES-1:0] edge_hit;
  logic [NUM_LINES-1:0] level_cause;
  logic [NUM_LINES-1:0] masked_edge;
  logic [NUM_LINES-1:0] total_cause;
  logic                 clr_we;
  logic                 addr_hit;

  gpio_irq_sync #(
    .WIDTH  (NUM_LINES),
    .STAGES (SYNC_DEPTH)
  ) i_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pin_in),
    .sync_out (sync_pin)
  );

  gpio_irq_regs #(
    .NUM_LINES (NUM_LINES),
    .ADDR_W    (ADDR_W)
  ) i_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_addr      (bus_addr),
    .bus_wr_en     (bus_wr_en),
    .bus_wdata     (bus_wdata),
    .sync_pin      (sync_pin),
    .line_is_input (line_is_input),
    .bus_rdata     (bus_rdata),
    .data_in       (data_in),
    .edge_cause    (edge_cause),
    .edge_mask     (edge_mask),
    .level_mask    (level_mask),
    .edge_hit      (edge_hit),
    .clr_we        (clr_we),
    .addr_hit      (addr_hit)
  );

  assign level_cause = data_in & level_mask & line_is_input;
  assign masked_edge = edge_cause & edge_mask;
  assign total_cause = level_cause | masked_edge;

  gpio_irq_group #(
    .NUM_LINES  (NUM_LINES),
    .GROUP_SIZE (GROUP_SIZE)
  ) i_group (
    .cause   (total_cause),
    .grp_irq (grp_irq)
  );

endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk #(
  parameter int NUM_LINES  = 32,
  parameter int NUM_GROUPS = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NUM_LINES-1:0]  edge_cause,
  input logic [NUM_LINES-1:0]  edge_hit,
  input logic [NUM_LINES-1:0]  edge_mask,
  input logic [NUM_LINES-1:0]  level_mask,
  input logic [NUM_LINES-1:0]  line_is_input,
  input logic [NUM_LINES-1:0]  bus_wdata,
  input logic [NUM_LINES-1:0]  bus_rdata,
  input logic                  clr_we,
  input logic                  addr_hit,
  input logic [NUM_GROUPS-1:0] grp_irq
);

  AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> ((edge_cause & $past(edge_cause)) == $past(edge_cause))); // R3

  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_hit) |=> ((edge_cause & $past(edge_hit)) == $past(edge_hit))); // R5

  AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && edge_hit == '0) |=> ((edge_cause & ~$past(bus_wdata)) == '0)); // R4

  AST_OUTPUT_LINE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((edge_cause & ~$past(edge_cause) & ~$past(line_is_input)) == '0)); // R9

  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_irq != '0) |-> ((edge_mask | level_mask) != '0)); // R7

  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_hit |=> (bus_rdata == '0)); // R10

endmodule

bind gpio_irq_agg gpio_irq_chk #(
  .NUM_LINES  (NUM_LINES),
  .NUM_GROUPS (NUM_GROUPS)
) i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .edge_cause    (edge_cause),
  .edge_hit      (edge_hit),
  .edge_mask     (edge_mask),
  .level_mask    (level_mask),
  .line_is_input (line_is_input),
  .bus_wdata     (bus_wdata),
  .bus_rdata     (bus_rdata),
  .clr_we        (clr_we),
  .addr_hit      (addr_hit),
  .grp_irq       (grp_irq)
);

// File: tb/test_gpio_irq_agg.sv
module test_gpio_irq_agg;

  localparam int CLK_PERIOD = 10;
  localparam int NL = 32;
  localparam int NG = 4;
  localparam int AW = 8;
  localparam int WATCHDOG = 150000;

  localparam logic [AW-1:0] A_POL = 8'h00;
  localparam logic [AW-1:0] A_DIN = 8'h04;
  localparam logic [AW-1:0] A_EC  = 8'h08;
  localparam logic [AW-1:0] A_EM  = 8'h0C;
  localparam logic [AW-1:0] A_LM  = 8'h10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] pin_in = '0;
  logic [NL-1:0] line_is_input = '1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr_en = 1'b0;
  logic [NL-1:0] bus_wdata = '0;
  logic [NL-1:0] bus_rdata;
  logic [NG-1:0] grp_irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_agg #(.NUM_LINES(NL), .GROUP_SIZE(8), .ADDR_W(AW)) i_gpio_irq_agg (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .line_is_input(line_is_input),
    .bus_addr(bus_addr), .bus_wr_en(bus_wr_en), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .grp_irq(grp_irq)
  );

  function automatic logic [NG-1:0] grp_of(input logic [NL-1:0] c);
    logic [NG-1:0] r = '0;
    for (int k = 0; k < NL; k++) if (c[k]) r[k/8] = 1'b1;
    return r;
  endfunction

  task automatic check(input string tag, input logic [NL-1:0] act, input logic [NL-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [NL-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [NL-1:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [NL-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 reset state
    check("R8 grp_irq", NL'(grp_irq), '0);
    rd(A_POL, v); check("R8 polarity", v, '0);
    rd(A_EC, v);  check("R8 edge cause", v, '0);
    rd(A_EM, v);  check("R8 edge mask", v, '0);
    rd(A_LM, v);  check("R8 level mask", v, '0);

    // R11 exact synchroniser delay
    wr(A_LM, 32'h1);
    @(negedge clk); pin_in = 32'h1;
    @(negedge clk); check("R11 after one edge", NL'(grp_irq), '0);
    @(negedge clk); check("R11 after two edges", NL'(grp_irq), 32'h1);
    pin_in = '0; wr(A_LM, '0); settle();

    // Level sweep over every line: R1 R2 R7
    for (int i = 0; i < NL; i++) begin
      logic [NL-1:0] b = NL'(1) << i;
      wr(A_LM, b);
      pin_in = b; settle();
      check("R2 R7 level high", NL'(grp_irq), NL'(grp_of(b)));
      rd(A_DIN, v); check("R1 data-in pol0", v, b);
      wr(A_POL, b); settle();
      check("R2 level inverted", NL'(grp_irq), '0);
      rd(A_DIN, v); check("R1 data-in pol1", v, '0);
      pin_in = '0; settle();
      check("R2 R7 active-low", NL'(grp_irq), NL'(grp_of(b)));
      wr(A_LM, '0); wr(A_POL, '0); settle();
    end

    // Edge sweep over every line: R3 R4 R6 R7
    for (int i = 0; i < NL; i++) begin
      logic [NL-1:0] b = NL'(1) << i;
      pin_in = '0; settle();
      wr(A_EC, '0); wr(A_EM, b);
      check("R6 idle", NL'(grp_irq), '0);
      pin_in = b; settle();
      rd(A_EC, v); check("R3 rising latched", v, b);
      check("R6 R7 edge irq", NL'(grp_irq), NL'(grp_of(b)));
      pin_in = '0; settle();
      rd(A_EC, v); check("R3 sticky", v, b);
      wr(A_EM, '0);
      check("R6 masked", NL'(grp_irq), '0);
      rd(A_EC, v); check("R6 mask keeps cause", v, b);
      wr(A_EM, b);
      wr(A_EC, ~b);
      rd(A_EC, v); check("R4 single clear", v, '0);
      check("R4 irq gone", NL'(grp_irq), '0);
      wr(A_EM, '0);
    end

    // R4 ones keep their value
    pin_in = '1; settle(); pin_in = '0; settle();
    rd(A_EC, v); check("R3 all set", v, '1);
    wr(A_EC, 32'hFFFF0000);
    rd(A_EC, v); check("R4 half clear", v, 32'hFFFF0000);
    wr(A_EC, 32'h7FFFFFFF);
    rd(A_EC, v); check("R4 top clear", v, 32'h7FFF0000);
    wr(A_EC, '0);

    // R3 falling edge via polarity
    pin_in = 32'h20; wr(A_POL, 32'h20); settle();
    wr(A_EC, '0);
    rd(A_EC, v); check("R3 no edge yet", v, '0);
    pin_in = '0; settle();
    rd(A_EC, v); check("R3 falling latched", v, 32'h20);
    wr(A_POL, '0); settle(); wr(A_EC, '0);

    // R9 output lines never cause
    line_is_input = ~32'h8;
    wr(A_LM, '1); wr(A_EM, '1);
    pin_in = 32'h8; settle();
    check("R9 no level", NL'(grp_irq), '0);
    rd(A_EC, v); check("R9 no edge", v, '0);
    pin_in = '0; settle();
    wr(A_LM, '0); wr(A_EM, '0);
    line_is_input = '1;

    // R5 new edge beats clear in the same cycle, other zero bits cleared
    pin_in = 32'h100; settle(); pin_in = '0; settle();
    rd(A_EC, v); check("R5 preset bit", v, 32'h100);
    @(negedge clk); pin_in = 32'h4;
    @(negedge clk);
    @(negedge clk);
    bus_addr = A_EC; bus_wdata = '0; bus_wr_en = 1'b1;
    @(negedge clk); bus_wr_en = 1'b0;
    rd(A_EC, v); check("R5 edge wins", v, 32'h4);
    pin_in = '0; settle(); wr(A_EC, '0);

    // R10 unmapped and read-only accesses
    wr(8'h40, '1);
    rd(8'h40, v); check("R10 unmapped reads zero", v, '0);
    rd(A_LM, v);  check("R10 level mask untouched", v, '0);
    rd(A_EM, v);  check("R10 edge mask untouched", v, '0);
    pin_in = 32'h00C0_0000; settle();
    wr(A_DIN, '0);
    rd(A_DIN, v); check("R1 R10 data-in read-only", v, 32'h00C0_0000);
    wr(A_LM, 32'h5A5A_A5A5);
    @(negedge clk); bus_addr = A_LM;
    @(posedge clk); #1;
    check("R10 one-cycle read", bus_rdata, 32'h5A5A_A5A5);

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule